// File: doc/BRIEF.md
# Eight-Channel Optical Audio Frame Transmitter

This block takes eight 24-bit audio samples per frame from a system-clock write port, together with a 4-bit user word. It packs them into a 256-bit serial frame and drives that frame, NRZI-coded, onto a single line clocked by an independent bit clock running at 256 times the sample rate. Software-free: a producer writes samples by channel index with a valid/ready handshake and marks the last sample of a frame.

The producer may write channels in any order and may rewrite a channel before closing the frame. Writing channel 7 with the last flag set closes the frame. The completed frame is then copied into a hand-off register, and a toggle is sent across to the bit-clock domain. The serializer swaps in the new frame only at a frame boundary. Until the serializer has taken the frame, the write port reports not-ready. When no new frame has arrived by a boundary, the serializer repeats the frame it has just sent.

Top module: `octa_frame_tx`

## Requirements
- R1: After reset, `ready_out` is 1, `tx_line` is 0, and the line carries frames whose eight channels and user bits are all zero until a frame is closed.
- R2: Each frame is 256 bits, sent in this order: 10 zero bits; a 1 bit; the 4 user bits, MSB first; channels 0 to 7, each sent as six groups of a 1 bit followed by a nibble, with the most significant nibble first and each nibble MSB first; a final 1 bit.
- R3: The line is NRZI-coded. A 1 bit toggles `tx_line` and a 0 bit leaves it unchanged. An all-zero frame therefore gives exactly 50 transitions.
- R4: A write is accepted when `valid_in` and `ready_out` are both 1 at a `clk` edge. It stores `sample_in` into channel `addr_in`. Channels may be written in any order, and a later write to a channel replaces the earlier one.
- R5: An accepted write with `last_in`=1 and `addr_in`=7 closes the frame. An accepted write with `last_in`=1 to any other channel is an ordinary write and does not close the frame.
- R6: The user bits carried by a closed frame are the value of `user_in` in the cycle of the closing write.
- R7: `ready_out` is 0 in the cycle after a closing write and stays 0 until the bit-clock domain has taken the frame. Writes presented while `ready_out` is 0 change nothing.
- R8: A new frame replaces the one being sent only at a frame boundary, so every frame on the line is whole.
- R9: When a boundary passes with no new closed frame waiting, the previous frame is sent again unchanged.
- R10: Channels not written since the last close keep their previous values in the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset, `clk` domain |
| bit_clk | input | 1 | Serial bit clock, 256 x sample rate |
| bit_rst | input | 1 | Synchronous active-high reset, `bit_clk` domain |
| valid_in | input | 1 | Sample write request |
| sample_in | input | 24 | Sample value |
| addr_in | input | 3 | Channel index 0..7 |
| last_in | input | 1 | Closes the frame when written with channel 7 |
| user_in | input | 4 | User bits, captured on the closing write |
| ready_out | output | 1 | Write port can accept a sample |
| tx_line | output | 1 | NRZI serial output, `bit_clk` domain |

## Verification
Two events can fall on the same cycle: a closed frame's request arriving in the bit-clock domain, and the serializer reaching its boundary bit, where it must choose between repeating the old frame and loading the new one. The bench uses system and bit clocks with an unrelated period ratio, so the arrival phase moves relative to the boundary from one frame to the next. It then closes a run of frames back to back, each as soon as `ready_out` returns. An independent NRZI decoder in the bench rebuilds every frame from the line and checks that its contents and separator bits match the model exactly, so a torn or skipped frame would show up as a mismatch.

// File: rtl/octa_tx_pkg.sv
package octa_tx_pkg;
    localparam int CHANS     = 8;
    localparam int SAMP_W    = 24;
    localparam int NIB_W     = 4;
    localparam int USER_W    = 4;
    localparam int SYNC_LEN  = 10;
    localparam int FRAME_LEN = 256;

    localparam int NIBS     = SAMP_W / NIB_W;
    localparam int SLOT_LEN = NIBS * (NIB_W + 1);
    localparam int HDR_LEN  = SYNC_LEN + 1 + USER_W;
    localparam int ADDR_W   = $clog2(CHANS);
    localparam int CNT_W    = $clog2(FRAME_LEN);
    localparam int SBIT_W   = $clog2(SAMP_W);
    localparam int UBIT_W   = $clog2(USER_W);

    typedef logic [SAMP_W-1:0]    sample_t;
    typedef sample_t [CHANS-1:0]  chan_set_t;
    typedef logic [USER_W-1:0]    user_t;
    typedef logic [FRAME_LEN-1:0] frame_t;

    // Wire bit i of the frame is held at vector position FRAME_LEN-1-i.
    function automatic frame_t build_frame(chan_set_t ch, user_t u);
        frame_t f;
        int     p;
        f = '0;
        f[CNT_W'(FRAME_LEN - 1 - SYNC_LEN)] = 1'b1;
        for (int i = 0; i < USER_W; i++)
            f[CNT_W'(FRAME_LEN - 2 - SYNC_LEN - i)] = u[UBIT_W'(USER_W - 1 - i)];
        for (int c = 0; c < CHANS; c++) begin
            for (int n = 0; n < NIBS; n++) begin
                p = HDR_LEN + c * SLOT_LEN + n * (NIB_W + 1);
                f[CNT_W'(FRAME_LEN - 1 - p)] = 1'b1;
                for (int b = 0; b < NIB_W; b++)
                    f[CNT_W'(FRAME_LEN - 2 - p - b)] =
                        ch[ADDR_W'(c)][SBIT_W'(SAMP_W - 1 - n * NIB_W - b)];
            end
        end
        f[0] = 1'b1;
        return f;
    endfunction
endpackage

// File: rtl/bit_sync.sv
module bit_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/frame_collect.sv
module frame_collect
    import octa_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              valid_in,
    input  logic [SAMP_W-1:0] sample_in,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              last_in,
    input  logic [USER_W-1:0] user_in,
    input  logic              ack_sync,
    output logic              ready,
    output frame_t            hold,
    output logic              req_tgl
);
    chan_set_t stage;
    chan_set_t merged;
    logic      accept;
    logic      close;

    assign ready  = (req_tgl == ack_sync);
    assign accept = valid_in && ready;
    assign close  = accept && last_in && (addr_in == ADDR_W'(CHANS - 1));

    always_comb begin
        merged = stage;
        if (accept) merged[addr_in] = sample_in;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stage   <= '0;
            hold    <= build_frame('0, '0);
            req_tgl <= 1'b0;
        end else begin
            if (accept) stage <= merged;
            if (close) begin
                hold    <= build_frame(merged, user_in);
                req_tgl <= ~req_tgl;
            end
        end
    end

    AST_READY_DROP: assert property (@(posedge clk) disable iff (rst)
        close |=> !ready); // R7
endmodule

// File: rtl/frame_serializer.sv
module frame_serializer
    import octa_tx_pkg::*;
(
    input  logic   bit_clk,
    input  logic   bit_rst,
    input  logic   req_sync,
    input  frame_t hold,
    output logic   ack_tgl,
    output logic   line
);
    logic [CNT_W-1:0] cnt;
    frame_t           shreg;
    logic             seen;
    logic             pending;
    logic             boundary;
    logic             tx_bit;

    assign pending  = (req_sync != seen);
    assign boundary = (cnt == CNT_W'(FRAME_LEN - 1));
    assign tx_bit   = shreg[FRAME_LEN-1];
    assign ack_tgl  = seen;

    always_ff @(posedge bit_clk) begin
        if (bit_rst) begin
            cnt   <= '0;
            shreg <= build_frame('0, '0);
            seen  <= 1'b0;
            line  <= 1'b0;
        end else begin
            line <= line ^ tx_bit;
            cnt  <= boundary ? '0 : cnt + 1'b1;
            if (boundary && pending) begin
                shreg <= hold;
                seen  <= req_sync;
            end else begin
                shreg <= {shreg[FRAME_LEN-2:0], shreg[FRAME_LEN-1]};
            end
        end
    end

    AST_SYNC_ZEROS: assert property (@(posedge bit_clk) disable iff (bit_rst)
        (cnt < CNT_W'(SYNC_LEN)) |-> !tx_bit); // R2
    AST_SYNC_MARK: assert property (@(posedge bit_clk) disable iff (bit_rst)
        (cnt == CNT_W'(SYNC_LEN)) |-> tx_bit); // R2
    AST_TAIL_MARK: assert property (@(posedge bit_clk) disable iff (bit_rst)
        boundary |-> tx_bit); // R2
    AST_SWAP_AT_EDGE: assert property (@(posedge bit_clk) disable iff (bit_rst)
        !$stable(seen) |-> $past(boundary)); // R8
endmodule

// File: rtl/octa_frame_tx.sv
module octa_frame_tx
    import octa_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_clk,
    input  logic              bit_rst,
    input  logic              valid_in,
    input  logic [SAMP_W-1:0] sample_in,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              last_in,
    input  logic [USER_W-1:0] user_in,
    output logic              ready_out,
    output logic              tx_line
);
    frame_t hold;
    logic   req_tgl;
    logic   req_sync;
    logic   ack_tgl;
    logic   ack_sync;

    frame_collect u_collect (
        .clk       (clk),
        .rst       (rst),
        .valid_in  (valid_in),
        .sample_in (sample_in),
        .addr_in   (addr_in),
        .last_in   (last_in),
        .user_in   (user_in),
        .ack_sync  (ack_sync),
        .ready     (ready_out),
        .hold      (hold),
        .req_tgl   (req_tgl)
    );

    bit_sync #(.STAGES(2)) u_req_sync (
        .clk (bit_clk),
        .rst (bit_rst),
        .d   (req_tgl),
        .q   (req_sync)
    );

    bit_sync #(.STAGES(2)) u_ack_sync (
        .clk (clk),
        .rst (rst),
        .d   (ack_tgl),
        .q   (ack_sync)
    );

    frame_serializer u_ser (
        .bit_clk  (bit_clk),
        .bit_rst  (bit_rst),
        .req_sync (req_sync),
        .hold     (hold),
        .ack_tgl  (ack_tgl),
        .line     (tx_line)
    );
endmodule

// File: tb/octa_frame_tx_bench.sv
module octa_frame_tx_bench;
    localparam int CLK_PERIOD = 10;
    localparam int BIT_PERIOD = 13;
    localparam int BODY = 245;

    localparam logic [23:0] TAB_S [4][8] = '{
        '{24'h123456, 24'h789ABC, 24'hDEF012, 24'h345678, 24'h9ABCDE, 24'hF01234, 24'h56789A, 24'hBCDEF0},
        '{24'hFFFFFF, 24'h000000, 24'hFFFFFF, 24'h000000, 24'h800001, 24'h7FFFFE, 24'h000001, 24'h800000},
        '{24'h0F0F0F, 24'hF0F0F0, 24'hA5A5A5, 24'h5A5A5A, 24'h111111, 24'h222222, 24'h333333, 24'h444444},
        '{24'hC0FFEE, 24'hBEEF01, 24'h00F00D, 24'hFACE55, 24'h0DDBA1, 24'h600D00, 24'hABCDEF, 24'h13579B}
    };
    localparam logic [3:0] TAB_U [4] = '{4'hF, 4'h1, 4'h8, 4'h6};

    logic clk = 0, bit_clk = 0, rst = 1, bit_rst = 1;
    logic valid_in = 0, last_in = 0;
    logic [23:0] sample_in = '0;
    logic [2:0]  addr_in = '0;
    logic [3:0]  user_in = '0;
    logic ready_out, tx_line;

    octa_frame_tx u_octa_frame_tx (
        .clk(clk), .rst(rst), .bit_clk(bit_clk), .bit_rst(bit_rst),
        .valid_in(valid_in), .sample_in(sample_in), .addr_in(addr_in),
        .last_in(last_in), .user_in(user_in),
        .ready_out(ready_out), .tx_line(tx_line)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always #(BIT_PERIOD/2.0) bit_clk = ~bit_clk;

    int n_run = 0, n_fail = 0;
    bit done = 0;

    task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // ---------------- independent line decoder ----------------
    logic prev_line, dbit;
    int zrun, idx, tog, dec_cnt = 0, dec_sep_bad, last_tog;
    bit collecting;
    logic body [BODY];
    logic [23:0] dec_ch [8];
    logic [3:0]  dec_user;

    always @(negedge bit_clk) begin
        if (bit_rst) begin
            prev_line = 0; zrun = 0; idx = 0; tog = 0; collecting = 0;
        end else begin
            dbit = tx_line ^ prev_line;
            prev_line = tx_line;
            if (dbit) tog++;
            if (collecting) begin
                body[idx] = dbit;
                idx++;
                if (idx == BODY) begin
                    dec_user = {body[0], body[1], body[2], body[3]};
                    dec_sep_bad = body[BODY-1] ? 0 : 1;
                    for (int c = 0; c < 8; c++)
                        for (int n = 0; n < 6; n++) begin
                            if (!body[4 + c*30 + n*5]) dec_sep_bad++;
                            for (int b = 0; b < 4; b++)
                                dec_ch[c][23 - 4*n - b] = body[5 + c*30 + n*5 + b];
                        end
                    last_tog = tog; tog = 0;
                    collecting = 0; zrun = 0; idx = 0;
                    dec_cnt++;
                end
            end else if (dbit) begin
                if (zrun >= 10) begin collecting = 1; idx = 0; end
                zrun = 0;
            end else begin
                zrun++;
            end
        end
    end

    // ---------------- bench model and tasks ----------------
    logic [23:0] model [8];
    logic [3:0]  model_user = 0;

    task automatic put(int a, logic [23:0] d, bit last, logic [3:0] u);
        @(negedge clk);
        while (!ready_out) @(negedge clk);
        valid_in = 1; addr_in = 3'(a); sample_in = d; last_in = last; user_in = u;
        model[a] = d;
        if (last && a == 7) model_user = u;
        @(negedge clk);
        valid_in = 0; last_in = 0;
    endtask

    task automatic next_decoded();
        int n;
        n = dec_cnt;
        while (dec_cnt == n) @(negedge bit_clk);
    endtask

    task automatic wait_frame();
        @(negedge clk);
        while (!ready_out) @(negedge clk);
        next_decoded();
    endtask

    task automatic check_frame(string req);
        int bad;
        bad = -1;
        for (int c = 7; c >= 0; c--) if (dec_ch[c] !== model[c]) bad = c;
        if (bad >= 0)
            check(0, req, $sformatf("channel %0d", bad), 64'(dec_ch[bad]), 64'(model[bad]));
        else
            check(1, req, "channels", 0, 0);
        check(dec_user === model_user, req, "user bits", 64'(dec_user), 64'(model_user));
        check(dec_sep_bad == 0, "R2", "separator errors", 64'(dec_sep_bad), 0);
    endtask

    initial begin
        for (int c = 0; c < 8; c++) model[c] = '0;
        repeat (4) @(posedge bit_clk);
        repeat (4) @(posedge clk);
        @(negedge clk); rst = 0;
        @(negedge bit_clk); bit_rst = 0;

        // R1: reset state
        @(negedge clk);
        check(ready_out === 1'b1, "R1", "ready after reset", 64'(ready_out), 1);
        check(tx_line === 1'b0, "R1", "line after reset", 64'(tx_line), 0);
        next_decoded();
        next_decoded();
        check_frame("R1");
        check(last_tog == 50, "R3", "transitions in idle frame", 64'(last_tog), 50);

        // R4/R5/R2: table of frames
        for (int v = 0; v < 4; v++) begin
            for (int a = 0; a < 8; a++) put(a, TAB_S[v][a], a == 7, TAB_U[v]);
            wait_frame();
            check_frame("R4");
        end

        // R9: repeat of the previous frame
        next_decoded();
        check_frame("R9");

        // R5: last flag on channel 3 does not close
        put(3, 24'h3A3A3A, 1, 4'h2);
        check(ready_out === 1'b1, "R5", "ready after last on ch3", 64'(ready_out), 1);
        model[3] = TAB_S[3][3];
        next_decoded();
        next_decoded();
        check_frame("R5");
        model[3] = 24'h3A3A3A;

        // R4/R10: out of order, rewrite, partial frame
        put(5, 24'h555000, 0, 4'h2);
        put(2, 24'h222000, 0, 4'h2);
        put(5, 24'h555FFF, 0, 4'h2);
        put(7, 24'h777777, 1, 4'h9);
        wait_frame();
        check_frame("R10");

        // R6: user bits from the closing cycle
        for (int a = 0; a < 7; a++) put(a, 24'h100000 * 24'(a + 1) + 24'h0000AB, 0, 4'h5);
        put(7, 24'h0C0C0C, 1, 4'hA);
        user_in = 4'h3;
        // R7: not ready after close, writes ignored while not ready
        check(ready_out === 1'b0, "R7", "ready after close", 64'(ready_out), 0);
        valid_in = 1; addr_in = 3'd0; sample_in = 24'hBADBAD; last_in = 0;
        while (!ready_out) @(negedge clk);
        valid_in = 0;
        next_decoded();
        check_frame("R6");
        put(7, 24'h0E0E0E, 1, 4'h4);
        wait_frame();
        check_frame("R7");

        // R8: back-to-back frames, request phase sweeps the boundary
        for (int k = 0; k < 6; k++) begin
            for (int a = 0; a < 8; a++)
                put(a, 24'((k * 8 + a) * 24'h02B3C5 + 24'h010101), a == 7, 4'(k + 3));
            wait_frame();
            check_frame("R8");
        end

        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule